// File: doc/BRIEF.md
# Bit-Slice ALU with Rotate

This block is an arithmetic and logic unit assembled from identical one-bit slices, four of them by default. Every slice sees one bit of the accumulator operand, one bit of the second operand (taken from a register or an immediate field), a carry input and the bits of its two neighbours. A three-bit opcode picks the function. The slices pass a carry from bit to bit. A small flag stage at the top of the chain produces the carry and overflow flags.

When the top opcode bit is set, every slice rotates the accumulator by one place. The lower two opcode bits are then ignored. The carry input does two jobs here: it selects the direction, and it supplies the bit that enters at the open end. The bit that leaves the word becomes the carry flag. The logical functions always report a carry of one.

The result and both flags are registered, so they appear one clock after the inputs. An asynchronous active-low reset clears them.

Top module: `bitslice_alu`

## Requirements
- R1: Opcode 000 adds the two operands and the carry input. result_o is the low WIDTH bits of the sum, and carry_o is the bit just above them.
- R2: Opcode 001 gives the bitwise AND of the operands, with carry_o at 1 and ovf_o at 0.
- R3: Opcode 010 gives the bitwise OR of the operands, with carry_o at 1 and ovf_o at 0.
- R4: Opcode 011 gives the bitwise XOR of the operands, with carry_o at 1 and ovf_o at 0.
- R5: When opcode bit 2 is 1, opcode bits 1 and 0 have no effect on any output.
- R6: Opcode 1xx with carry_i at 0 moves the accumulator one place right. A 0 (the carry input) enters at the MSB, the old LSB goes to carry_o, and ovf_o is 0.
- R7: Opcode 1xx with carry_i at 1 moves the accumulator one place left. A 1 (the carry input) enters at the LSB, the old MSB goes to carry_o, and ovf_o is 0.
- R8: For opcode 000, ovf_o is the XOR of the carry into the MSB and the carry out of the MSB, which is two's-complement overflow. For every other opcode, ovf_o is 0.
- R9: Outputs change on the clock edge after the inputs are applied. While rst_n is low, result_o, carry_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode; bit 2 selects rotate |
| acc_i | input | WIDTH | Accumulator operand |
| opb_i | input | WIDTH | Register or immediate operand |
| carry_i | input | 1 | Carry in; sets direction and fill bit for rotates |
| result_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
Every opcode is applied with every accumulator value, every second operand and both carry inputs. Sums that stay in range are therefore separated from sums that carry or overflow in either sign.

The rotate opcodes are repeated with all four settings of the ignored bits and with varying second operands. This shows that the direction comes from the carry input alone. The edge bits then show the fill value and the bit that leaves the word.

The logical opcodes, run with carry_i at both 0 and 1, show that the carry input does not reach their results and that their carry flag stays at one.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_AND = 3'b001,
        OP_OR  = 3'b010,
        OP_XOR = 3'b011
    } alu_op_e;

    function automatic logic op_is_rotate(input logic [2:0] op);
        return op[2];
    endfunction

    function automatic logic op_is_add(input logic [2:0] op);
        return (op == OP_ADD);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import bitslice_alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       hi_nb,
    input  logic       lo_nb,
    output logic       dout,
    output logic       cout
);

    always_comb begin
        if (op_is_rotate(op)) begin
            // carry passes through unchanged so every slice sees the direction
            dout = cin ? lo_nb : hi_nb;
            cout = cin;
        end else begin
            case (op[1:0])
                2'b00: begin
                    dout = a ^ b ^ cin;
                    cout = (a & b) | (cin & (a ^ b));
                end
                2'b01: begin
                    dout = a & b;
                    cout = 1'b1;
                end
                2'b10: begin
                    dout = a | b;
                    cout = 1'b1;
                end
                default: begin
                    dout = a ^ b;
                    cout = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import bitslice_alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       carry_in,
    input  logic       acc_msb,
    input  logic       acc_lsb,
    input  logic       c_into_msb,
    input  logic       c_out_msb,
    output logic       carry_flag,
    output logic       ovf_flag
);

    always_comb begin
        if (op_is_rotate(op)) begin
            carry_flag = carry_in ? acc_msb : acc_lsb;
        end else begin
            carry_flag = c_out_msb;
        end
        ovf_flag = op_is_add(op) ? (c_into_msb ^ c_out_msb) : 1'b0;
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             c;
        logic             v;
    } out_t;

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] slice_out;
    logic             carry_flag;
    logic             ovf_flag;
    out_t             out_d, out_q;

    assign chain[0] = carry_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic hi_nb;
        logic lo_nb;
        if (i == MSB) begin : g_top
            assign hi_nb = carry_i;
        end else begin : g_mid_hi
            assign hi_nb = acc_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_nb = carry_i;
        end else begin : g_mid_lo
            assign lo_nb = acc_i[i-1];
        end
        alu_slice u_slice (
            .op    (op_i),
            .a     (acc_i[i]),
            .b     (opb_i[i]),
            .cin   (chain[i]),
            .hi_nb (hi_nb),
            .lo_nb (lo_nb),
            .dout  (slice_out[i]),
            .cout  (chain[i+1])
        );
    end

    alu_flag_gen u_flags (
        .op         (op_i),
        .carry_in   (carry_i),
        .acc_msb    (acc_i[MSB]),
        .acc_lsb    (acc_i[0]),
        .c_into_msb (chain[MSB]),
        .c_out_msb  (chain[WIDTH]),
        .carry_flag (carry_flag),
        .ovf_flag   (ovf_flag)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = slice_out;
        out_d.c   = carry_flag;
        out_d.v   = ovf_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign carry_o  = out_q.c;
    assign ovf_o    = out_q.v;

    // logical opcodes leave carry at one on the following cycle
    assert_logic_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_i[2]) && ($past(op_i[1:0]) != 2'b00)) |-> carry_o);

    assert_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) != 3'b000)) |-> !ovf_o);

    assert_rot_right_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[2]) && !$past(carry_i))
        |-> (!result_o[MSB] && (carry_o == $past(acc_i[0]))));

    assert_rot_left_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[2]) && $past(carry_i))
        |-> (result_o[0] && (carry_o == $past(acc_i[MSB]))));

    assert_hold_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (result_o == '0 && !carry_o && !ovf_o));

endmodule

// File: tb/bitslice_alu_tb_top.sv
`timescale 1ns/1ps
module bitslice_alu_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [W-1:0] acc_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         carry_i = 1'b0;
    logic [W-1:0] result_o;
    logic         carry_o;
    logic         ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opb_i    (opb_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_o),
        .ovf_o    (ovf_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: result, carry, overflow
    task automatic ref_model(input int op, input int a, input int b, input int c,
                             output int r, output int co, output int v, output string req);
        int mask = (1 << W) - 1;
        int msb  = 1 << (W - 1);
        int s;
        v = 0;
        if (op >= 4) begin
            if (c == 0) begin
                r = a >> 1; co = a & 1; req = (op != 4) ? "R5/R6" : "R6";
            end else begin
                r = ((a << 1) | 1) & mask; co = (a >> (W - 1)) & 1;
                req = (op != 4) ? "R5/R7" : "R7";
            end
        end else begin
            case (op)
                0: begin
                    s = a + b + c; r = s & mask; co = (s >> W) & 1;
                    v = (((a ^ r) & (b ^ r) & msb) != 0) ? 1 : 0;
                    req = "R1/R8";
                end
                1: begin r = a & b; co = 1; req = "R2"; end
                2: begin r = a | b; co = 1; req = "R3"; end
                default: begin r = a ^ b; co = 1; req = "R4"; end
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int er, ec, ev;
        string rq;
        op_i = 3'b011; acc_i = 4'hF; opb_i = 4'hF; carry_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", result_o, 0, "result in reset");
        check("R9", carry_o, 0, "carry in reset");
        check("R9", ovf_o, 0, "ovf in reset");
        rst_n = 1'b1;
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    for (int c = 0; c < 2; c++) begin
                        op_i = op[2:0]; acc_i = a[W-1:0]; opb_i = b[W-1:0]; carry_i = c[0];
                        ref_model(op, a, b, c, er, ec, ev, rq);
                        @(negedge clk);
                        check(rq, result_o, er, "result");
                        check(rq, carry_o, ec, "carry");
                        check((rq == "R1/R8") ? rq : "R8", ovf_o, ev, "ovf");
                    end
                end
            end
        end
        // R9: output appears one edge later and holds when inputs are stable
        op_i = 3'b000; acc_i = 4'h7; opb_i = 4'h1; carry_i = 1'b0;
        @(negedge clk);
        check("R9", result_o, 8, "registered sum");
        check("R8", ovf_o, 1, "positive overflow 7+1");
        op_i = 3'b001;
        #1;
        check("R9", result_o, 8, "no change before edge");
        @(negedge clk);
        check("R9", result_o, 1, "AND after edge");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule